// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits between a flash array and its data pins. It watches the two active-low read strobes, chip select and output enable. When both are active it drives a 16-bit word onto the read path, one cycle after sampling. While the device is idle, that word is the array data presented to it. While an internal word program or erase is running, it is a status word instead.

The status word lets a host poll for completion. Bit 7 carries the inverse of bit 7 of the word being programmed, or zero during an erase. Bit 6 flips on every new read access. All other bits are zero.

The block also times the operation itself. A start pulse for a program or an erase raises `busy` for a fixed number of clock cycles, set by a parameter. When that count runs out, `busy` falls and `op_done` pulses. Start pulses that arrive while an operation runs are dropped. The synchronous reset aborts any operation, floats the outputs and returns the block to plain reads.

Top module: `embedded_status_reporter`

## Requirements
- R1: After reset, `busy`, `op_done` and `dout_en` are 0 and `dout` is all zeros.
- R2: `dout_en` is 1 in the cycle after one in which `ce_n` and `oe_n` were both sampled low, and 0 otherwise; `dout` is all zeros whenever `dout_en` is 0.
- R3: When a read is sampled with `busy` low, `dout` in the next cycle equals the `array_data` sampled with it.
- R4: A start accepted while idle raises `busy` in the next cycle. `busy` stays high for exactly PROG_CYCLES cycles for a program and ERASE_CYCLES cycles for an erase.
- R5: For a read sampled during a program, `dout[7]` is the inverse of `prog_poll_bit` as sampled with the accepted start.
- R6: For a read sampled during an erase, `dout[7]` is 0.
- R7: A new access is the first cycle in which both strobes are low after a cycle in which either was high. Each new access sampled during `busy` inverts `dout[6]` relative to the previous status access. Holding the strobes low keeps `dout[6]` steady. The toggle state is 0 after reset.
- R8: For a read sampled during `busy`, every `dout` bit other than 7 and 6 is 0.
- R9: `start_prog` and `start_erase` sampled while `busy` is high are ignored: the kind, poll value and duration of the running operation are unchanged.
- R10: Reset sampled high forces `busy`, `dout_en` and `dout` to 0 in the next cycle, aborting any operation.
- R11: `op_done` is high for exactly the one cycle in which `busy` has just fallen at the natural end of an operation. It never pulses after a reset abort.
- R12: If `start_prog` and `start_erase` are both sampled high while idle, a program is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also aborts a running operation |
| start_prog | input | 1 | Pulse: begin a word program |
| start_erase | input | 1 | Pulse: begin an erase |
| prog_poll_bit | input | 1 | Bit 7 of the word being programmed, sampled with the start |
| ce_n | input | 1 | Chip select strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| array_data | input | DATA_W | Stored word at the current read address |
| dout | output | DATA_W | Registered read data or status word |
| dout_en | output | 1 | Output driver enable (1 = drive, 0 = float) |
| busy | output | 1 | Embedded operation in progress |
| op_done | output | 1 | One-cycle pulse at natural completion |

## Verification
Completion and a new read access can land in the same cycle. The read must then report status, because `busy` was still high when it was sampled, and the following read must return true array data. The bench provokes this by polling with short strobe periods that sweep across the final busy cycles of a program. It also holds the strobes low straight through a completion. A second collision is a start pulse arriving while an operation is already running. A behavioural model running alongside the design judges every cycle on `dout`, `dout_en`, `busy` and `op_done`. Separate checks confirm that the measured busy lengths match the requested operation kind.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_t;
endpackage

// File: rtl/esr_op_timer.sv
module esr_op_timer
  import esr_pkg::*;
#(
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_prog,
  input  logic     start_erase,
  input  logic     prog_poll_bit,
  output logic     busy,
  output logic     op_done,
  output op_kind_t op_kind,
  output logic     poll_val
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW      = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] PROG_LOAD  = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ERASE_LOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      op_done  <= 1'b0;
      cnt_q    <= '0;
      op_kind  <= OP_PROG;
      poll_val <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (busy) begin
        // starts are dropped here (R9)
        if (cnt_q == '0) begin
          busy    <= 1'b0;
          op_done <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (start_prog) begin
        // program wins a tie with erase (R12)
        busy     <= 1'b1;
        op_kind  <= OP_PROG;
        poll_val <= ~prog_poll_bit;
        cnt_q    <= PROG_LOAD;
      end else if (start_erase) begin
        busy     <= 1'b1;
        op_kind  <= OP_ERASE;
        poll_val <= 1'b0;
        cnt_q    <= ERASE_LOAD;
      end
    end
  end
endmodule

// File: rtl/esr_access_detect.sv
module esr_access_detect (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic oe_n,
  output logic rd_act,
  output logic acc_start
);
  logic rd_prev_q;

  assign rd_act    = ~ce_n & ~oe_n;
  assign acc_start = rd_act & ~rd_prev_q;

  always_ff @(posedge clk) begin
    if (rst) rd_prev_q <= 1'b0;
    else     rd_prev_q <= rd_act;
  end
endmodule

// File: rtl/esr_status_mux.sv
module esr_status_mux
  import esr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_act,
  input  logic              acc_start,
  input  logic              busy,
  input  op_kind_t          op_kind,
  input  logic              poll_val,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              tog_q;
  logic              tog_next;
  logic [DATA_W-1:0] status_w;

  assign tog_next = acc_start ? ~tog_q : tog_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      assign status_w[b] = (op_kind == OP_ERASE) ? 1'b0 : poll_val;
    end else if (b == TOGGLE_BIT) begin : g_tog
      assign status_w[b] = tog_next;
    end else begin : g_zero
      assign status_w[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q   <= 1'b0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      if (busy && acc_start) tog_q <= ~tog_q;
      dout_en <= rd_act;
      if (!rd_act)   dout <= '0;
      else if (busy) dout <= status_w;
      else           dout <= array_data;
    end
  end
endmodule

// File: rtl/embedded_status_reporter.sv
module embedded_status_reporter
  import esr_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int PROG_CYCLES  = 20,
  parameter int ERASE_CYCLES = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              prog_poll_bit,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              op_done
);
  op_kind_t op_kind;
  logic     poll_val;
  logic     rd_act;
  logic     acc_start;

  esr_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk          (clk),
    .rst          (rst),
    .start_prog   (start_prog),
    .start_erase  (start_erase),
    .prog_poll_bit(prog_poll_bit),
    .busy         (busy),
    .op_done      (op_done),
    .op_kind      (op_kind),
    .poll_val     (poll_val)
  );

  esr_access_detect u_access (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .rd_act   (rd_act),
    .acc_start(acc_start)
  );

  esr_status_mux #(
    .DATA_W(DATA_W)
  ) u_mux (
    .clk       (clk),
    .rst       (rst),
    .rd_act    (rd_act),
    .acc_start (acc_start),
    .busy      (busy),
    .op_kind   (op_kind),
    .poll_val  (poll_val),
    .array_data(array_data),
    .dout      (dout),
    .dout_en   (dout_en)
  );
endmodule

// File: rtl/esr_checker.sv
module esr_checker
  import esr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_prog,
  input logic              start_erase,
  input logic              ce_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              busy,
  input logic              op_done,
  input op_kind_t          op_kind
);
  localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'((1 << POLL_BIT) | (1 << TOGGLE_BIT));

  AST_EN_TRACKS_READ: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n) |=> dout_en); // R2
  AST_FLOAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> (dout == '0)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    ((start_prog || start_erase) && !busy) |=> busy); // R4
  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(busy) && $past(op_kind == OP_ERASE)) |-> !dout[POLL_BIT]); // R6
  AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (rst)
    (dout_en && $past(busy)) |-> ((dout & ~STAT_MASK) == '0)); // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (!busy && $past(busy))); // R11
  AST_RESET_ABORT: assert property (@(posedge clk)
    rst |=> (!busy && !dout_en && !op_done)); // R10
endmodule

bind embedded_status_reporter esr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_prog (start_prog),
  .start_erase(start_erase),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .dout       (dout),
  .dout_en    (dout_en),
  .busy       (busy),
  .op_done    (op_done),
  .op_kind    (op_kind)
);

// File: tb/test_embedded_status_reporter.sv
`timescale 1ns/1ps
module test_embedded_status_reporter;
  localparam int DW = 16;
  localparam int PC = 20;
  localparam int EC = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_prog = 1'b0, start_erase = 1'b0, prog_poll_bit = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] array_data = '0;
  logic [DW-1:0] dout;
  logic dout_en, busy, op_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  embedded_status_reporter #(.DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) i_embedded_status_reporter (
    .clk(clk), .rst(rst), .start_prog(start_prog), .start_erase(start_erase),
    .prog_poll_bit(prog_poll_bit), .ce_n(ce_n), .oe_n(oe_n), .array_data(array_data),
    .dout(dout), .dout_en(dout_en), .busy(busy), .op_done(op_done));

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done, m_en, m_stat, m_erase_out, m_erase, m_pv, m_tog, m_prev;
  int m_left;
  logic [DW-1:0] m_dout;

  always @(posedge clk) begin
    bit rd, acc;
    if (rst) begin
      m_busy = 0; m_done = 0; m_en = 0; m_stat = 0; m_tog = 0; m_prev = 0;
      m_dout = '0; m_left = 0;
    end else begin
      rd  = !ce_n && !oe_n;
      acc = rd && !m_prev;
      m_en = rd;
      m_stat = rd && m_busy;
      m_erase_out = m_erase;
      if (!rd) m_dout = '0;
      else if (m_busy) begin
        if (acc) m_tog = !m_tog;
        m_dout = '0;
        m_dout[7] = m_erase ? 1'b0 : m_pv;
        m_dout[6] = m_tog;
      end else m_dout = array_data;
      m_done = 0;
      if (m_busy) begin
        if (m_left == 1) begin m_busy = 0; m_done = 1; end
        else m_left--;
      end else if (start_prog) begin
        m_busy = 1; m_erase = 0; m_pv = !prog_poll_bit; m_left = PC;
      end else if (start_erase) begin
        m_busy = 1; m_erase = 1; m_pv = 0; m_left = EC;
      end
      m_prev = rd;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      check("R2", dout_en === m_en, dout_en, m_en);
      check("R4", busy === m_busy, busy, m_busy);
      check("R11", op_done === m_done, op_done, m_done);
      if (m_stat) begin
        check(m_erase_out ? "R6" : "R5", dout[7] === m_dout[7], dout[7], m_dout[7]);
        check("R7", dout[6] === m_dout[6], dout[6], m_dout[6]);
        check("R8", (dout & 16'hFF3F) === (m_dout & 16'hFF3F), dout, m_dout);
      end else begin
        check("R3", dout === m_dout, dout, m_dout);
      end
    end
  end

  // busy run length, cleared without recording on reset
  int run = 0;
  int last_len = 0;
  always @(negedge clk) begin
    if (rst) run = 0;
    else if (busy) run++;
    else if (run > 0) begin last_len = run; run = 0; end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_idle();
    while (busy) cyc(1);
    cyc(1);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    check("R1", busy == 0 && dout_en == 0 && dout == '0 && op_done == 0, {dout_en, busy, dout}, 0);

    // idle reads, OE-controlled then CE-controlled (R3)
    ce_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      array_data = 16'h1357 * (i + 1) ^ 16'hA5C3;
      oe_n = 1'b0; cyc(2);
      array_data = ~array_data;
      cyc(1);
      oe_n = 1'b1; cyc(1);
    end
    ce_n = 1'b1; oe_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      array_data = 16'hF00F >> i;
      ce_n = 1'b0; cyc(2);
      ce_n = 1'b1; cyc(1);
    end
    oe_n = 1'b1;

    // program with poll bit 1, polled by OE, a stray erase start (R9)
    prog_poll_bit = 1'b1; start_prog = 1'b1; cyc(1);
    start_prog = 1'b0; prog_poll_bit = 1'b0;
    ce_n = 1'b0;
    repeat (4) begin oe_n = 1'b0; cyc(1); oe_n = 1'b1; cyc(1); end
    start_erase = 1'b1; cyc(1); start_erase = 1'b0;
    oe_n = 1'b0; array_data = 16'hBEEF;
    cyc(PC);                      // held straight through completion
    oe_n = 1'b1; ce_n = 1'b1;
    wait_idle();
    check("R9", last_len == PC, last_len, PC);

    // erase polled by CE
    start_erase = 1'b1; cyc(1); start_erase = 1'b0;
    oe_n = 1'b0;
    repeat (8) begin ce_n = 1'b0; cyc(2); ce_n = 1'b1; cyc(1); end
    ce_n = 1'b0; cyc(1);
    check("R6", dout_en == 1 && dout[7] == 0, dout, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    wait_idle();
    check("R4", last_len == EC, last_len, EC);

    // simultaneous starts, program expected (R12), poll bit 0
    prog_poll_bit = 1'b0; start_prog = 1'b1; start_erase = 1'b1; cyc(1);
    start_prog = 1'b0; start_erase = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0; cyc(3);
    check("R12", dout[7] == 1'b1, dout[7], 1);
    oe_n = 1'b1;
    wait_idle();
    check("R12", last_len == PC, last_len, PC);

    // access starts sweeping across the completion edge
    for (int ph = 0; ph < 3; ph++) begin
      start_prog = 1'b1; prog_poll_bit = ph[0]; cyc(1); start_prog = 1'b0;
      cyc(PC - 4 + ph);
      repeat (4) begin
        array_data = array_data + 16'h0111;
        oe_n = 1'b0; cyc(1); oe_n = 1'b1; cyc(1);
      end
      wait_idle();
    end
    ce_n = 1'b1;

    // reset abort mid erase
    start_erase = 1'b1; cyc(1); start_erase = 1'b0;
    cyc(5);
    ce_n = 1'b0; oe_n = 1'b0; cyc(2);
    rst = 1'b1; cyc(1);
    check("R10", busy == 0 && dout_en == 0 && dout == '0, {dout_en, busy, dout}, 0);
    rst = 1'b0; cyc(1);
    check("R11", op_done == 0, op_done, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    cyc(EC + 4);
    check("R11", op_done == 0 && busy == 0, {op_done, busy}, 0);

    summary();
  end
endmodule